// File: doc/BRIEF.md
# IR Carrier Waveform Generator

This block makes the square carrier that modulates an infrared LED. A period is a high phase followed by a low phase. Each phase length is programmed separately and counted in ticks of a modulator clock. That tick comes from one of four sources, all derived from the fast system clock and a crystal strobe. A symbol sequencer drives the gate input to key the carrier on and off, and the carrier period counter keeps running whether the gate is open or shut.

Software reaches two write-only registers over a simple word-addressed bus. The control word holds the enable, a hold that forces the output to its initial high level, and the tick source. The modulation word holds both phase lengths, each stored minus one. A newly written modulation word is held in a shadow and is copied in only at a period boundary, or at once while the generator is stopped, so that no period is ever shortened. The block also emits a one-cycle strobe at every period boundary, which can serve as a timebase.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, `carrier_o` and `period_tick_o` are low and both registers read as zero in effect (generator stopped, system-clock tick source).
- R2: Register select is by word address: address 0 is the control word and address 1 is the modulation word. A write happens in any cycle with `wr_en_i` high.
- R3: Modulation word layout: bits 31:16 hold (low-phase ticks - 1) and bits 15:0 hold (high-phase ticks - 1). While running, the high phase lasts hi+1 ticks and the low phase lasts lo+1 ticks. Every period starts with its high phase.
- R4: Control bits 13:12 pick the tick source. 0 ticks every system clock cycle. 1 ticks on every third `xtal_strobe_i` pulse. 2 ticks every US_DIV system cycles (1 us). 3 ticks every 10*US_DIV system cycles (10 us).
- R5: Control bit 0 enables the generator. While it is clear, `carrier_o` is low and the counters are held at the start of a high phase. The tick dividers are cleared. The modulation word written last is loaded directly. Once enable is set, the high phase begins in the cycle after the write.
- R6: Control bit 2 forces `carrier_o` high whatever the enable and the gate. While it is set the counters are held as in R5 and no period strobe is produced.
- R7: A modulation word written while running takes effect only at the next period boundary. The period under way completes with the old lengths.
- R8: With `gate_i` low and no forced-high hold, `carrier_o` is low. The period counter keeps running and `period_tick_o` keeps its spacing.
- R9: `period_tick_o` is a one-cycle pulse. It is high in the first cycle of each new period (the first period after enabling excepted). The spacing is (hi+lo+2) ticks. With the gate open, the carrier is high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Word address (0 control, 1 modulation) |
| wr_data_i | input | 32 | Write data |
| xtal_strobe_i | input | 1 | One-cycle pulse per crystal clock edge, synchronous to clk_i |
| gate_i | input | 1 | Carrier gate from the symbol sequencer |
| carrier_o | output | 1 | Modulated carrier output |
| period_tick_o | output | 1 | One-cycle strobe at each carrier period boundary |

## Verification
The bench builds the block with US_DIV = 4 and the default 16-bit phase counters. With that divider the 1 us and 10 us sources tick every 4 and 40 cycles, so every tick source, including the slowest, can be measured over several full periods within a short run. The 16-bit counts still take the sub-field positions of the word, so the field layout is exercised exactly, and phase counts of zero reach the fastest one-cycle carrier.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;

  typedef enum logic [1:0] {
    SRC_SYS   = 2'd0,
    SRC_XTAL3 = 2'd1,
    SRC_US1   = 2'd2,
    SRC_US10  = 2'd3
  } tick_src_e;

  localparam int unsigned DATA_W       = 32;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_INIT_BIT = 2;
  localparam int unsigned CTRL_SRC_LSB = 12;
  localparam int unsigned MOD_LO_LSB   = 16;
  localparam int unsigned MOD_HI_LSB   = 0;
  localparam int unsigned ADDR_CTRL    = 0;
  localparam int unsigned ADDR_MOD     = 1;
  localparam int unsigned XTAL_DIV     = 3;
  localparam int unsigned TEN_DIV      = 10;

  typedef struct packed {
    tick_src_e src;
    logic      init_high;
    logic      en;
  } ctrl_t;

endpackage

// File: rtl/ir_carrier_regs.sv
module ir_carrier_regs
  import ir_carrier_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output ctrl_t                ctrl_o,
  output logic [CNT_W-1:0]     hi_cnt_o,
  output logic [CNT_W-1:0]     lo_cnt_o
);

  logic wr_ctrl, wr_mod;
  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));
  assign wr_mod  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_MOD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '{src: SRC_SYS, init_high: 1'b0, en: 1'b0};
    end else if (wr_ctrl) begin
      ctrl_o.en        <= wr_data_i[CTRL_EN_BIT];
      ctrl_o.init_high <= wr_data_i[CTRL_INIT_BIT];
      ctrl_o.src       <= tick_src_e'(wr_data_i[CTRL_SRC_LSB +: 2]);
    end
  end

  // shadow copy; the phase counter decides when it becomes active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_o <= '0;
      lo_cnt_o <= '0;
    end else if (wr_mod) begin
      hi_cnt_o <= wr_data_i[MOD_HI_LSB +: CNT_W];
      lo_cnt_o <= wr_data_i[MOD_LO_LSB +: CNT_W];
    end
  end

endmodule

// File: rtl/ir_tick_gen.sv
module ir_tick_gen
  import ir_carrier_pkg::*;
#(
  parameter int unsigned US_DIV = 24
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  tick_src_e src_i,
  input  logic      xtal_strobe_i,
  output logic      tick_o
);

  localparam int unsigned US_W  = (US_DIV > 1) ? $clog2(US_DIV) : 1;
  localparam int unsigned TEN_W = $clog2(TEN_DIV);
  localparam int unsigned X_W   = $clog2(XTAL_DIV);

  logic [US_W-1:0]  us_cnt;
  logic [TEN_W-1:0] ten_cnt;
  logic [X_W-1:0]   x_cnt;
  logic us_tick, ten_tick, x_tick;

  generate
    if (US_DIV > 1) begin : g_us_div
      assign us_tick = !clr_i && (us_cnt == US_W'(US_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      us_cnt <= '0;
        else if (clr_i)   us_cnt <= '0;
        else if (us_tick) us_cnt <= '0;
        else              us_cnt <= us_cnt + 1'b1;
      end
    end else begin : g_us_pass
      assign us_tick = !clr_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) us_cnt <= '0;
        else         us_cnt <= '0;
      end
    end
  endgenerate

  assign ten_tick = us_tick && (ten_cnt == TEN_W'(TEN_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ten_cnt <= '0;
    else if (clr_i)    ten_cnt <= '0;
    else if (ten_tick) ten_cnt <= '0;
    else if (us_tick)  ten_cnt <= ten_cnt + 1'b1;
  end

  assign x_tick = !clr_i && xtal_strobe_i && (x_cnt == X_W'(XTAL_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            x_cnt <= '0;
    else if (clr_i)         x_cnt <= '0;
    else if (x_tick)        x_cnt <= '0;
    else if (xtal_strobe_i) x_cnt <= x_cnt + 1'b1;
  end

  always_comb begin
    unique case (src_i)
      SRC_SYS:   tick_o = !clr_i;
      SRC_XTAL3: tick_o = x_tick;
      SRC_US1:   tick_o = us_tick;
      SRC_US10:  tick_o = ten_tick;
      default:   tick_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/ir_phase_ctr.sv
module ir_phase_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   hi_cnt_i,
  input  logic [CNT_W-1:0]   lo_cnt_i,
  output logic               phase_hi_o,
  output logic               boundary_o,
  output logic [2*CNT_W-1:0] act_word_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_hi, act_lo;

  assign act_hi     = act_word_o[CNT_W-1:0];
  assign act_lo     = act_word_o[2*CNT_W-1:CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_hi_o <= 1'b1;
      cnt_q      <= '0;
      act_word_o <= '0;
      boundary_o <= 1'b0;
    end else begin
      boundary_o <= 1'b0;
      if (!run_i) begin
        phase_hi_o <= 1'b1;
        cnt_q      <= '0;
        act_word_o <= {lo_cnt_i, hi_cnt_i};
      end else if (tick_i) begin
        if (phase_hi_o) begin
          if (cnt_q == act_hi) begin
            phase_hi_o <= 1'b0;
            cnt_q      <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else if (cnt_q == act_lo) begin
          // period boundary: restart high, adopt shadow word
          phase_hi_o <= 1'b1;
          cnt_q      <= '0;
          act_word_o <= {lo_cnt_i, hi_cnt_i};
          boundary_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned US_DIV = 24,
  parameter int unsigned ADDR_W = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              xtal_strobe_i,
  input  logic              gate_i,
  output logic              carrier_o,
  output logic              period_tick_o
);

  ctrl_t               ctrl_s;
  logic [CNT_W-1:0]    hi_cnt_s, lo_cnt_s;
  logic [2*CNT_W-1:0]  act_word_s;
  logic                run_s, init_hi_s, tick_s, phase_hi_s;

  ir_carrier_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .ctrl_o    (ctrl_s),
    .hi_cnt_o  (hi_cnt_s),
    .lo_cnt_o  (lo_cnt_s)
  );

  assign init_hi_s = ctrl_s.init_high;
  assign run_s     = ctrl_s.en && !ctrl_s.init_high;

  ir_tick_gen #(.US_DIV(US_DIV)) u_tick (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clr_i         (!run_s),
    .src_i         (ctrl_s.src),
    .xtal_strobe_i (xtal_strobe_i),
    .tick_o        (tick_s)
  );

  ir_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_s),
    .tick_i     (tick_s),
    .hi_cnt_i   (hi_cnt_s),
    .lo_cnt_i   (lo_cnt_s),
    .phase_hi_o (phase_hi_s),
    .boundary_o (period_tick_o),
    .act_word_o (act_word_s)
  );

  assign carrier_o = init_hi_s || (run_s && gate_i && phase_hi_s);

endmodule

// File: rtl/ir_carrier_chk.sv
module ir_carrier_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               gate_i,
  input logic               carrier_o,
  input logic               period_tick_o,
  input logic               run_s,
  input logic               init_hi_s,
  input logic [2*CNT_W-1:0] act_word_s
);

  p_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_s && !init_hi_s) |-> !carrier_o);

  p_init_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_hi_s |-> carrier_o);

  p_gate_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gate_i && !init_hi_s) |-> !carrier_o);

  p_tick_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_tick_o |=> !period_tick_o);

  p_tick_starts_high_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_tick_o && run_s && gate_i) |-> carrier_o);

  p_word_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_s) && !period_tick_o) |-> $stable(act_word_s));

endmodule

bind ir_carrier_gen ir_carrier_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .gate_i        (gate_i),
  .carrier_o     (carrier_o),
  .period_tick_o (period_tick_o),
  .run_s         (run_s),
  .init_hi_s     (init_hi_s),
  .act_word_s    (act_word_s)
);

// File: tb/ir_carrier_gen_bench.sv
module ir_carrier_gen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int US_DIV     = 4;
  localparam int WD_CYCLES  = 20000;

  typedef struct packed {
    logic lvl;
    int   len;   // 0: length not checked
  } seg_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [0:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        xtal_strobe_i = 1'b0;
  logic        gate_i = 1'b1;
  logic        carrier_o, period_tick_o;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   armed = 0;
  bit   started = 0;
  bit   xtal_on = 0;
  logic cur_lvl = 1'b0;
  int   cur_len = 0;
  string cur_req = "";
  seg_t exp_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ir_carrier_gen #(.CNT_W(16), .US_DIV(US_DIV), .ADDR_W(1)) u_ir_carrier_gen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_en_i       (wr_en_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .xtal_strobe_i (xtal_strobe_i),
    .gate_i        (gate_i),
    .carrier_o     (carrier_o),
    .period_tick_o (period_tick_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // crystal strobe every second cycle when enabled
  always @(negedge clk_i) xtal_strobe_i = xtal_on ? ~xtal_strobe_i : 1'b0;

  // monitor: measures carrier segments and pops expected ones
  always @(negedge clk_i) begin
    if (armed) begin
      if (!started) begin
        if (carrier_o) begin
          started = 1; cur_lvl = 1'b1; cur_len = 1;
        end
      end else if (carrier_o === cur_lvl) begin
        cur_len++;
      end else begin
        seg_t e;
        e = exp_q.pop_front();
        check({cur_req, " level"}, int'(cur_lvl), int'(e.lvl));
        if (e.len != 0) check({cur_req, " length"}, cur_len, e.len);
        cur_lvl = carrier_o; cur_len = 1;
        if (exp_q.size() == 0) begin
          armed = 0; started = 0;
        end
      end
    end
  end

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 1'(addr); wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_w(input int src, input bit en, input bit init);
    return (32'(src) << 12) | (32'(init) << 2) | 32'(en);
  endfunction

  function automatic logic [31:0] mod_w(input int hi, input int lo);
    return (32'(lo) << 16) | 32'(hi);
  endfunction

  // driver: program while stopped, queue expected segments, then start
  task automatic run_case(input string req, input int src, input int hi, input int lo,
                          input int tper, input int nper, input bit skip_first);
    wr(0, ctrl_w(src, 0, 0));
    wr(1, mod_w(hi, lo));
    cur_req = req;
    for (int p = 0; p < nper; p++) begin
      exp_q.push_back('{lvl: 1'b1, len: (p == 0 && skip_first) ? 0 : (hi + 1) * tper});
      exp_q.push_back('{lvl: 1'b0, len: (lo + 1) * tper});
    end
    armed = 1;
    wr(0, ctrl_w(src, 1, 0));
    wait (!armed);
    wr(0, ctrl_w(src, 0, 0));
  endtask

  task automatic tick_spacing(input string req, input int exp_gap, input int exp_car);
    int gap;
    int guard;
    guard = 0;
    while (!period_tick_o && guard < 2000) begin
      @(negedge clk_i); guard++;
    end
    check({req, " carrier at strobe"}, int'(carrier_o), exp_car);
    gap = 0;
    do begin
      @(negedge clk_i); gap++;
    end while (!period_tick_o && gap < 2000);
    check({req, " strobe spacing"}, gap, exp_gap);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int hi_seen;
    int ticks_seen;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 carrier", int'(carrier_o), 0);
    check("R1 tick", int'(period_tick_o), 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 idle after reset", int'(carrier_o), 0);

    // R2 R3 R4: system-clock ticks, address 1 layout
    run_case("R3 sys src", 0, 2, 4, 1, 3, 0);
    // R4 1 us source
    run_case("R4 us1 src", 2, 1, 2, US_DIV, 3, 0);
    // R4 10 us source
    run_case("R4 us10 src", 3, 0, 1, 10 * US_DIV, 2, 0);
    // R4 crystal / 3, strobe every 2 cycles -> tick every 6
    xtal_on = 1;
    run_case("R4 xtal src", 1, 1, 0, 6, 3, 1);
    xtal_on = 0;
    // R3 shortest phases
    run_case("R3 zero counts", 0, 0, 0, 1, 4, 0);

    // R7 deferred modulation word
    wr(0, ctrl_w(0, 0, 0));
    wr(1, mod_w(3, 3));
    cur_req = "R7 deferred word";
    exp_q.push_back('{lvl: 1'b1, len: 4});
    exp_q.push_back('{lvl: 1'b0, len: 4});
    for (int p = 0; p < 2; p++) begin
      exp_q.push_back('{lvl: 1'b1, len: 2});
      exp_q.push_back('{lvl: 1'b0, len: 2});
    end
    armed = 1;
    wr(0, ctrl_w(0, 1, 0));
    wr(1, mod_w(1, 1));
    wait (!armed);
    wr(0, ctrl_w(0, 0, 0));

    // R9 strobe spacing with gate open
    wr(1, mod_w(2, 4));
    wr(0, ctrl_w(0, 1, 0));
    tick_spacing("R9", 8, 1);

    // R8 gate closed: carrier low, strobe continues
    gate_i = 1'b0;
    hi_seen = 0;
    ticks_seen = 0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_i);
      if (carrier_o) hi_seen++;
      if (period_tick_o) ticks_seen++;
    end
    check("R8 carrier low with gate closed", hi_seen, 0);
    check("R8 strobes with gate closed", ticks_seen, 4);
    tick_spacing("R8", 8, 0);
    gate_i = 1'b1;

    // R5 enable cleared mid-run
    wr(0, ctrl_w(0, 0, 0));
    hi_seen = 0;
    ticks_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (carrier_o) hi_seen++;
      if (period_tick_o) ticks_seen++;
    end
    check("R5 carrier idle when disabled", hi_seen, 0);
    check("R5 no strobe when disabled", ticks_seen, 0);

    // R6 forced high, with and without enable
    wr(0, ctrl_w(0, 0, 1));
    @(negedge clk_i);
    check("R6 forced high disabled", int'(carrier_o), 1);
    gate_i = 1'b0;
    wr(0, ctrl_w(0, 1, 1));
    hi_seen = 0;
    ticks_seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (carrier_o) hi_seen++;
      if (period_tick_o) ticks_seen++;
    end
    check("R6 forced high over gate", hi_seen, 20);
    check("R6 counters held", ticks_seen, 0);
    gate_i = 1'b1;
    wr(0, ctrl_w(0, 0, 0));
    @(negedge clk_i);
    check("R6 released", int'(carrier_o), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule